// File: doc/BRIEF.md
# Data Watchpoint Address Comparator

This block watches the data accesses of one load/store port and flags those that touch a programmed address window. Software programs two registers through a simple write port. One is a watch address, whose two lowest bits are always stored as zero. The other is a control word that selects the window shape, the access direction, the privilege and security filters, and an optional link to a context-ID comparator.

The window takes one of two shapes. The first is a power-of-two aligned region chosen by a size exponent. The second is a short run of bytes next to the watch address, picked by an 8-bit byte-select field. Each presented access is first adjusted for legacy byte-invariant big-endian addressing. It is then tested for overlap with the window, and the filters are applied. When everything agrees, the block reports a hit one clock later, together with the direction and the address as presented. The context-capable breakpoint slots that a link may name are not stored here. Their enable, type and context value arrive on input ports from the surrounding debug logic.

Top module: `wp_match_unit`

## Requirements
- R1: A write with `cfg_sel`=0 stores the watch address with bits 1:0 forced to zero. A write with `cfg_sel`=1 stores the control word from `cfg_wdata[25:0]`, laid out as enable[0], privilege-select[2:1] (bit 1 allows level 1, bit 2 allows level 0), direction[4:3], byte-select[12:5], high-level-allow[13], security-select[15:14], link-slot[19:16], link-enable[20] and size-exponent[25:21]. A write in cycle N governs accesses presented from cycle N+1 onward.
- R2: With enable clear, nothing hits. Direction 0 watches nothing, 1 watches reads, 2 watches writes and 3 watches both.
- R3: A size exponent of 1 or 2 watches nothing. An exponent m of 3 or more watches the 2^m bytes of the aligned block that contains the watch address.
- R4: With a size exponent of 0, the byte-select field applies. Only its low 4 bits count when watch-address bit 2 is set. A zero byte-select watches nothing. Otherwise the window starts at the watch address plus the index of the lowest set bit, and it spans only the unbroken run of ones from that bit.
- R5: Security-select 0 accepts both states, 1 and 3 accept only non-secure accesses, and 2 accepts only secure ones.
- R6: Accesses at level 2 or 3 require high-level-allow. Level 1 requires privilege-select bit 1 of the register (field bit 0), and level 0 requires field bit 1. An access flagged unprivileged is judged as level 0.
- R7: With link-enable set, a hit also requires three things. The link-slot must name one of the top `NUM_CTX` of `NUM_BP` slots. That slot must be enabled with a type of 3, 7 or 13. Its context value must equal `acc_ctx`. Any other type fails.
- R8: No hit is reported unless both `mon_en` and `dbg_exc_en` are high.
- R9: When `be_invariant` is high, a 1-byte access address is XORed with 3 and a 2-byte access address with 2 before the overlap test. `acc_size` encodes 1, 2, 4 or 8 bytes as 0 to 3.
- R10: An access hits when any of its bytes lies in the window. `hit`, `hit_wnr` (equal to `acc_write`) and `hit_addr` (equal to the unadjusted `acc_addr`) appear in the cycle after the access. On cycles with no hit, `hit_wnr` and `hit_addr` are zero.
- R11: After reset, `hit`, `hit_wnr` and `hit_addr` are zero and both registers read as cleared, so nothing is watched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 selects the watch address, 1 the control word |
| cfg_wdata | input | ADDR_W | Register write data |
| mon_en | input | 1 | Global watchpoint enable from the debug control register |
| dbg_exc_en | input | 1 | Debug exceptions currently permitted |
| be_invariant | input | 1 | Legacy byte-invariant big-endian mode |
| ctx_en | input | NUM_CTX | Enable of each context-capable breakpoint slot |
| ctx_type | input | 4*NUM_CTX | Type code of each context-capable slot |
| ctx_value | input | CTX_W*NUM_CTX | Context value of each context-capable slot |
| acc_valid | input | 1 | A data access is presented |
| acc_addr | input | ADDR_W | Access address |
| acc_size | input | 2 | Log2 of the access size in bytes |
| acc_write | input | 1 | 1 for a store, 0 for a load |
| acc_level | input | 2 | Privilege level of the access |
| acc_unpriv | input | 1 | Access carries an unprivileged hint |
| acc_secure | input | 1 | Access is in the secure state |
| acc_ctx | input | CTX_W | Current context ID |
| hit | output | 1 | Registered match flag |
| hit_wnr | output | 1 | Registered write-not-read of the matching access |
| hit_addr | output | ADDR_W | Registered address of the matching access |

## Verification
The assertions take every input as a known level that is sampled only at the rising edge. Their `$past` terms then stand for the access, the stored registers and the enables that produced a hit. They also rely on a register write and an access in the same cycle being judged against the old register contents. The stimulus changes all inputs on the falling edge and holds them for a whole cycle. It sometimes lands register writes next to accesses, so that the one-cycle ordering is exercised without leaving that assumption.

// File: rtl/wp_pkg.sv
package wp_pkg;

    localparam int CTL_W = 26;

    localparam logic       SEL_ADDR = 1'b0;
    localparam logic       SEL_CTL  = 1'b1;

    localparam logic [1:0] SEC_ANY    = 2'd0;
    localparam logic [1:0] SEC_NS     = 2'd1;
    localparam logic [1:0] SEC_S      = 2'd2;
    localparam logic [1:0] SEC_NS_ALT = 2'd3;

    localparam logic [3:0] LINK_T_CUR  = 4'd3;
    localparam logic [3:0] LINK_T_LOW  = 4'd7;
    localparam logic [3:0] LINK_T_HYP  = 4'd13;

    typedef struct packed {
        logic [4:0] size_exp;
        logic       link_en;
        logic [3:0] link_slot;
        logic [1:0] sec_sel;
        logic       hi_allow;
        logic [7:0] byte_sel;
        logic [1:0] dir;
        logic [1:0] priv_sel;
        logic       enable;
    } wp_ctl_t;

    function automatic logic [3:0] lowest_one(input logic [7:0] v);
        logic [3:0] idx;
        idx = 4'd8;
        for (int i = 7; i >= 0; i--) begin
            if (v[i]) idx = 4'(i);
        end
        return idx;
    endfunction

    function automatic logic [3:0] run_length(input logic [7:0] v, input logic [3:0] from);
        logic [3:0] cnt;
        logic       broken;
        cnt    = 4'd0;
        broken = 1'b0;
        for (int i = 0; i < 8; i++) begin
            if (4'(i) >= from && !broken) begin
                if (v[i]) cnt = cnt + 4'd1;
                else      broken = 1'b1;
            end
        end
        return cnt;
    endfunction

endpackage

// File: rtl/wp_range_decode.sv
module wp_range_decode
    import wp_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:2] watch_addr,
    input  wp_ctl_t           ctl,
    output logic [ADDR_W:0]   win_base,
    output logic [ADDR_W:0]   win_len,
    output logic              win_valid
);
    localparam logic [ADDR_W:0] ONE = {{ADDR_W{1'b0}}, 1'b1};

    logic [ADDR_W-1:0] full_addr;
    logic [ADDR_W-1:0] low_mask;
    logic [7:0]        sel_eff;
    logic [3:0]        first;
    logic [3:0]        span;

    assign full_addr = {watch_addr, 2'b00};

    always_comb begin
        win_base  = '0;
        win_len   = '0;
        win_valid = 1'b0;
        low_mask  = '0;
        sel_eff   = watch_addr[2] ? {4'b0000, ctl.byte_sel[3:0]} : ctl.byte_sel;
        first     = lowest_one(sel_eff);
        span      = run_length(sel_eff, first);
        if (ctl.size_exp != 5'd0) begin
            if (ctl.size_exp >= 5'd3 && int'(ctl.size_exp) < ADDR_W) begin
                win_len   = ONE << ctl.size_exp;
                low_mask  = win_len[ADDR_W-1:0] - {{(ADDR_W-1){1'b0}}, 1'b1};
                win_base  = {1'b0, full_addr & ~low_mask};
                win_valid = 1'b1;
            end
        end else if (sel_eff != 8'd0) begin
            win_base  = {1'b0, full_addr} + {{(ADDR_W-3){1'b0}}, first};
            win_len   = {{(ADDR_W-3){1'b0}}, span};
            win_valid = 1'b1;
        end
    end

endmodule

// File: rtl/wp_access_filter.sv
module wp_access_filter
    import wp_pkg::*;
#(
    parameter int NUM_BP  = 6,
    parameter int NUM_CTX = 2,
    parameter int CTX_W   = 32
) (
    input  wp_ctl_t                    ctl,
    input  logic [1:0]                 acc_level,
    input  logic                       acc_unpriv,
    input  logic                       acc_secure,
    input  logic [CTX_W-1:0]           acc_ctx,
    input  logic [NUM_CTX-1:0]         ctx_en,
    input  logic [NUM_CTX*4-1:0]       ctx_type,
    input  logic [NUM_CTX*CTX_W-1:0]   ctx_value,
    output logic                       pass
);
    localparam int FIRST_CTX = NUM_BP - NUM_CTX;

    logic [NUM_CTX-1:0] slot_ok;
    logic               link_ok;
    logic               sec_ok;
    logic               priv_ok;
    logic [1:0]         eff_level;

    for (genvar s = 0; s < NUM_CTX; s++) begin : g_slot
        logic [3:0] t;
        assign t = ctx_type[s*4 +: 4];
        assign slot_ok[s] = ctx_en[s]
                          && (t == LINK_T_CUR || t == LINK_T_LOW || t == LINK_T_HYP)
                          && (ctx_value[s*CTX_W +: CTX_W] == acc_ctx);
    end

    always_comb begin
        link_ok = 1'b0;
        for (int s = 0; s < NUM_CTX; s++) begin
            if (int'(ctl.link_slot) == FIRST_CTX + s) link_ok = slot_ok[s];
        end
    end

    always_comb begin
        unique case (ctl.sec_sel)
            SEC_ANY:    sec_ok = 1'b1;
            SEC_NS:     sec_ok = !acc_secure;
            SEC_S:      sec_ok = acc_secure;
            SEC_NS_ALT: sec_ok = !acc_secure;
            default:    sec_ok = 1'b0;
        endcase
    end

    assign eff_level = acc_unpriv ? 2'd0 : acc_level;

    always_comb begin
        unique case (eff_level)
            2'd3, 2'd2: priv_ok = ctl.hi_allow;
            2'd1:       priv_ok = ctl.priv_sel[0];
            default:    priv_ok = ctl.priv_sel[1];
        endcase
    end

    assign pass = sec_ok && priv_ok && (!ctl.link_en || link_ok);

endmodule

// File: rtl/wp_match_unit.sv
module wp_match_unit
    import wp_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int NUM_BP  = 6,
    parameter int NUM_CTX = 2,
    parameter int CTX_W   = 32
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       cfg_we,
    input  logic                       cfg_sel,
    input  logic [ADDR_W-1:0]          cfg_wdata,
    input  logic                       mon_en,
    input  logic                       dbg_exc_en,
    input  logic                       be_invariant,
    input  logic [NUM_CTX-1:0]         ctx_en,
    input  logic [NUM_CTX*4-1:0]       ctx_type,
    input  logic [NUM_CTX*CTX_W-1:0]   ctx_value,
    input  logic                       acc_valid,
    input  logic [ADDR_W-1:0]          acc_addr,
    input  logic [1:0]                 acc_size,
    input  logic                       acc_write,
    input  logic [1:0]                 acc_level,
    input  logic                       acc_unpriv,
    input  logic                       acc_secure,
    input  logic [CTX_W-1:0]           acc_ctx,
    output logic                       hit,
    output logic                       hit_wnr,
    output logic [ADDR_W-1:0]          hit_addr
);
    localparam logic [ADDR_W:0] ONE = {{ADDR_W{1'b0}}, 1'b1};

    logic [ADDR_W-1:2] watch_q;
    wp_ctl_t           ctl_q;

    logic [ADDR_W:0]   win_base;
    logic [ADDR_W:0]   win_len;
    logic              win_valid;
    logic              filt_pass;
    logic [ADDR_W-1:0] adj_addr;
    logic [ADDR_W:0]   acc_lo;
    logic [ADDR_W:0]   acc_hi;
    logic [ADDR_W:0]   win_hi;
    logic              overlap;
    logic              dir_ok;
    logic              hit_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            watch_q <= '0;
            ctl_q   <= '0;
        end else if (cfg_we) begin
            if (cfg_sel == SEL_ADDR) watch_q <= cfg_wdata[ADDR_W-1:2];
            else                     ctl_q   <= wp_ctl_t'(cfg_wdata[CTL_W-1:0]);
        end
    end

    wp_range_decode #(.ADDR_W(ADDR_W)) u_range (
        .watch_addr (watch_q),
        .ctl        (ctl_q),
        .win_base   (win_base),
        .win_len    (win_len),
        .win_valid  (win_valid)
    );

    wp_access_filter #(.NUM_BP(NUM_BP), .NUM_CTX(NUM_CTX), .CTX_W(CTX_W)) u_filter (
        .ctl        (ctl_q),
        .acc_level  (acc_level),
        .acc_unpriv (acc_unpriv),
        .acc_secure (acc_secure),
        .acc_ctx    (acc_ctx),
        .ctx_en     (ctx_en),
        .ctx_type   (ctx_type),
        .ctx_value  (ctx_value),
        .pass       (filt_pass)
    );

    always_comb begin
        adj_addr = acc_addr;
        if (be_invariant) begin
            if (acc_size == 2'd0)      adj_addr[1:0] = acc_addr[1:0] ^ 2'b11;
            else if (acc_size == 2'd1) adj_addr[1]   = ~acc_addr[1];
        end
    end

    assign acc_lo  = {1'b0, adj_addr};
    assign acc_hi  = acc_lo + (ONE << acc_size);
    assign win_hi  = win_base + win_len;
    assign overlap = (acc_lo < win_hi) && (win_base < acc_hi);
    assign dir_ok  = acc_write ? ctl_q.dir[1] : ctl_q.dir[0];

    assign hit_d = acc_valid && mon_en && dbg_exc_en && ctl_q.enable
                && win_valid && dir_ok && filt_pass && overlap;

    always_ff @(posedge clk) begin
        if (rst) begin
            hit      <= 1'b0;
            hit_wnr  <= 1'b0;
            hit_addr <= '0;
        end else begin
            hit      <= hit_d;
            hit_wnr  <= hit_d && acc_write;
            hit_addr <= hit_d ? acc_addr : '0;
        end
    end

    a_r10_wnr_follows: assert property (@(posedge clk) disable iff (rst)
        hit |-> (hit_wnr == $past(acc_write)));
    a_r10_addr_follows: assert property (@(posedge clk) disable iff (rst)
        hit |-> (hit_addr == $past(acc_addr)));
    a_r10_needs_access: assert property (@(posedge clk) disable iff (rst)
        hit |-> $past(acc_valid));
    a_r10_quiet_zero: assert property (@(posedge clk) disable iff (rst)
        !hit |-> (!hit_wnr && hit_addr == '0));
    a_r8_global_gate: assert property (@(posedge clk) disable iff (rst)
        hit |-> $past(mon_en && dbg_exc_en));
    a_r2_store_allowed: assert property (@(posedge clk) disable iff (rst)
        (hit && hit_wnr) |-> $past(ctl_q.dir[1]));
    a_r6_unpriv_level0: assert property (@(posedge clk) disable iff (rst)
        (hit && $past(acc_unpriv)) |-> $past(ctl_q.priv_sel[1]));
    a_r5_secure_only: assert property (@(posedge clk) disable iff (rst)
        (hit && $past(ctl_q.sec_sel) == SEC_S) |-> $past(acc_secure));
    a_r3_reserved_exp: assert property (@(posedge clk) disable iff (rst)
        hit |-> ($past(ctl_q.size_exp) != 5'd1 && $past(ctl_q.size_exp) != 5'd2));

endmodule

// File: tb/tb_wp_match_unit.sv
module tb_wp_match_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we, cfg_sel;
    logic [31:0] cfg_wdata;
    logic        mon_en, dbg_exc_en, be_invariant;
    logic [1:0]  ctx_en;
    logic [7:0]  ctx_type;
    logic [63:0] ctx_value;
    logic        acc_valid;
    logic [31:0] acc_addr;
    logic [1:0]  acc_size;
    logic        acc_write;
    logic [1:0]  acc_level;
    logic        acc_unpriv, acc_secure;
    logic [31:0] acc_ctx;
    logic        hit, hit_wnr;
    logic [31:0] hit_addr;

    wp_match_unit dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .mon_en(mon_en), .dbg_exc_en(dbg_exc_en), .be_invariant(be_invariant),
        .ctx_en(ctx_en), .ctx_type(ctx_type), .ctx_value(ctx_value),
        .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_size(acc_size),
        .acc_write(acc_write), .acc_level(acc_level), .acc_unpriv(acc_unpriv),
        .acc_secure(acc_secure), .acc_ctx(acc_ctx),
        .hit(hit), .hit_wnr(hit_wnr), .hit_addr(hit_addr)
    );

    always #5 clk = ~clk;

    int     n_checks = 0;
    int     n_errors = 0;
    int     cycles   = 0;
    bit     checking = 1'b0;
    string  tag      = "R11";

    longint    m_addr;
    bit [31:0] m_ctl;
    bit        e_hit, e_wnr;
    bit [31:0] e_addr;

    function automatic bit [31:0] mk_ctl(bit en, bit [1:0] psel, bit [1:0] dir, bit [7:0] bsel,
                                         bit hia, bit [1:0] sec, bit [3:0] slot, bit lnk, bit [4:0] ex);
        bit [31:0] c;
        c = '0;
        c[0] = en; c[2:1] = psel; c[4:3] = dir; c[12:5] = bsel; c[13] = hia;
        c[15:14] = sec; c[19:16] = slot; c[20] = lnk; c[25:21] = ex;
        return c;
    endfunction

    function automatic bit ref_hit(longint wa, bit [31:0] c, longint a, int sz, bit wr, int lvl,
                                   bit up, bit sec, bit be, bit men, bit den, bit [1:0] cen,
                                   bit [7:0] ctyp, bit [63:0] cval, bit [31:0] actx);
        int     ex, el, idx, bsel, first, span, t;
        longint ad, lo, x;
        bit     any;
        ex = int'(c[25:21]);
        if (!men || !den || !c[0]) return 0;
        if (wr ? !c[4] : !c[3]) return 0;
        if (c[15:14] == 2 && !sec) return 0;
        if ((c[15:14] == 1 || c[15:14] == 3) && sec) return 0;
        el = up ? 0 : lvl;
        if (el >= 2 && !c[13]) return 0;
        if (el == 1 && !c[1]) return 0;
        if (el == 0 && !c[2]) return 0;
        if (c[20]) begin
            idx = int'(c[19:16]) - 4;
            if (idx < 0 || idx > 1) return 0;
            if (!cen[idx]) return 0;
            t = int'(ctyp[idx*4 +: 4]);
            if (t != 3 && t != 7 && t != 13) return 0;
            if (cval[idx*32 +: 32] != actx) return 0;
        end
        if (ex == 1 || ex == 2) return 0;
        bsel = int'(c[12:5]);
        if (wa[2]) bsel = bsel % 16;
        if (ex == 0 && bsel == 0) return 0;
        first = 0;
        while (ex == 0 && ((bsel >> first) & 1) == 0) first++;
        span = 0;
        while (ex == 0 && first + span < 8 && ((bsel >> (first + span)) & 1) == 1) span++;
        lo = wa + first;
        ad = a;
        if (be && sz == 0) ad = a ^ 3;
        if (be && sz == 1) ad = a ^ 2;
        any = 0;
        for (int k = 0; k < (1 << sz); k++) begin
            x = ad + k;
            if (ex != 0) begin
                if ((x >> ex) == (wa >> ex)) any = 1;
            end else if (x >= lo && x < lo + span) any = 1;
        end
        return any;
    endfunction

    // Behavioural reference: next-cycle expectation and register copies
    always @(posedge clk) begin
        bit h;
        if (rst) begin
            e_hit <= 0; e_wnr <= 0; e_addr <= '0; m_addr <= 0; m_ctl <= '0;
        end else begin
            h = acc_valid && ref_hit(m_addr, m_ctl, longint'(acc_addr), int'(acc_size), acc_write,
                                     int'(acc_level), acc_unpriv, acc_secure, be_invariant, mon_en,
                                     dbg_exc_en, ctx_en, ctx_type, ctx_value, acc_ctx);
            e_hit  <= h;
            e_wnr  <= h && acc_write;
            e_addr <= h ? acc_addr : 32'h0;
            if (cfg_we && !cfg_sel) m_addr <= longint'(cfg_wdata & 32'hFFFF_FFFC);
            if (cfg_we && cfg_sel)  m_ctl  <= cfg_wdata & 32'h03FF_FFFF;
        end
    end

    always @(negedge clk) begin
        cycles++;
        if (checking) begin
            n_checks++;
            if (hit !== e_hit || hit_wnr !== e_wnr || hit_addr !== e_addr) begin
                n_errors++;
                $display("FAIL %s: hit/wnr/addr actual %b/%b/%h expected %b/%b/%h",
                         tag, hit, hit_wnr, hit_addr, e_hit, e_wnr, e_addr);
            end
        end
        if (cycles > 100000) begin
            n_errors++;
            $display("FAIL watchdog: actual cycles %0d expected under 100000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    task automatic wr(bit sel, bit [31:0] d);
        cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic acc(bit [31:0] a, bit [1:0] sz, bit w, bit [1:0] lvl, bit up, bit sec);
        acc_valid = 1; acc_addr = a; acc_size = sz; acc_write = w;
        acc_level = lvl; acc_unpriv = up; acc_secure = sec;
        @(negedge clk);
        acc_valid = 0;
    endtask

    initial begin
        rst = 1; cfg_we = 0; cfg_sel = 0; cfg_wdata = 0;
        mon_en = 1; dbg_exc_en = 1; be_invariant = 0;
        ctx_en = 0; ctx_type = 0; ctx_value = 0;
        acc_valid = 0; acc_addr = 0; acc_size = 0; acc_write = 0;
        acc_level = 1; acc_unpriv = 0; acc_secure = 0; acc_ctx = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        checking = 1;
        // R11: reset state, nothing watched
        tag = "R11";
        acc(32'h0, 0, 0, 1, 0, 0);
        repeat (2) @(negedge clk);

        // R1: low address bits dropped on write
        tag = "R1";
        wr(0, 32'h1003);
        wr(1, mk_ctl(1, 3, 3, 8'h01, 1, 0, 0, 0, 0));
        acc(32'h1000, 0, 0, 1, 0, 0);
        acc(32'h1001, 0, 0, 1, 0, 0);
        acc(32'h1003, 0, 1, 1, 0, 0);
        @(negedge clk);

        // R2: enable and direction
        tag = "R2";
        wr(1, mk_ctl(0, 3, 3, 8'h01, 1, 0, 0, 0, 0)); acc(32'h1000, 0, 0, 1, 0, 0);
        wr(1, mk_ctl(1, 3, 1, 8'h01, 1, 0, 0, 0, 0)); acc(32'h1000, 0, 0, 1, 0, 0); acc(32'h1000, 0, 1, 1, 0, 0);
        wr(1, mk_ctl(1, 3, 2, 8'h01, 1, 0, 0, 0, 0)); acc(32'h1000, 0, 0, 1, 0, 0); acc(32'h1000, 0, 1, 1, 0, 0);
        wr(1, mk_ctl(1, 3, 0, 8'h01, 1, 0, 0, 0, 0)); acc(32'h1000, 0, 1, 1, 0, 0);
        @(negedge clk);

        // R3: size exponent windows
        tag = "R3";
        wr(0, 32'h2345);
        wr(1, mk_ctl(1, 3, 3, 8'hFF, 1, 0, 0, 0, 1)); acc(32'h2344, 0, 0, 1, 0, 0);
        wr(1, mk_ctl(1, 3, 3, 8'hFF, 1, 0, 0, 0, 2)); acc(32'h2344, 0, 0, 1, 0, 0);
        wr(1, mk_ctl(1, 3, 3, 8'h00, 1, 0, 0, 0, 8));
        acc(32'h23FF, 0, 0, 1, 0, 0); acc(32'h2400, 0, 0, 1, 0, 0);
        acc(32'h2300, 0, 0, 1, 0, 0); acc(32'h22F8, 3, 1, 1, 0, 0);
        @(negedge clk);

        // R4: byte-select decoding
        tag = "R4";
        wr(0, 32'h3004);
        wr(1, mk_ctl(1, 3, 3, 8'hF0, 1, 0, 0, 0, 0)); acc(32'h3004, 2, 0, 1, 0, 0);
        wr(0, 32'h3000);
        wr(1, mk_ctl(1, 3, 3, 8'h36, 1, 0, 0, 0, 0));
        acc(32'h3000, 0, 0, 1, 0, 0); acc(32'h3002, 0, 0, 1, 0, 0);
        acc(32'h3004, 0, 0, 1, 0, 0); acc(32'h3005, 0, 0, 1, 0, 0); acc(32'h3003, 0, 0, 1, 0, 0);
        wr(1, mk_ctl(1, 3, 3, 8'h00, 1, 0, 0, 0, 0)); acc(32'h3000, 3, 0, 1, 0, 0);
        @(negedge clk);

        // R5: security filter
        tag = "R5";
        for (int s = 0; s < 4; s++) begin
            wr(1, mk_ctl(1, 3, 3, 8'hFF, 1, 2'(s), 0, 0, 0));
            acc(32'h3000, 0, 0, 1, 0, 0); acc(32'h3000, 0, 0, 1, 0, 1);
        end
        @(negedge clk);

        // R6: privilege filter
        tag = "R6";
        for (int p = 0; p < 8; p++) begin
            wr(1, mk_ctl(1, 2'(p), 3, 8'hFF, p[2], 0, 0, 0, 0));
            for (int l = 0; l < 4; l++) acc(32'h3001, 0, 0, 2'(l), 0, 0);
            acc(32'h3001, 0, 0, 1, 1, 0);
        end
        @(negedge clk);

        // R7: linked context comparator
        tag = "R7";
        acc_ctx = 32'hABCD; ctx_en = 2'b01; ctx_type = 8'h07; ctx_value = {32'h5555, 32'hABCD};
        wr(1, mk_ctl(1, 3, 3, 8'hFF, 1, 0, 4, 1, 0));
        acc(32'h3000, 0, 0, 1, 0, 0);
        acc_ctx = 32'hABCE; acc(32'h3000, 0, 0, 1, 0, 0); acc_ctx = 32'hABCD;
        ctx_type = 8'h09; acc(32'h3000, 0, 0, 1, 0, 0);
        ctx_type = 8'h03; acc(32'h3000, 0, 0, 1, 0, 0);
        ctx_en = 2'b00; acc(32'h3000, 0, 0, 1, 0, 0); ctx_en = 2'b11;
        wr(1, mk_ctl(1, 3, 3, 8'hFF, 1, 0, 3, 1, 0)); acc(32'h3000, 0, 0, 1, 0, 0);
        ctx_type = 8'hD3; acc_ctx = 32'h5555;
        wr(1, mk_ctl(1, 3, 3, 8'hFF, 1, 0, 5, 1, 0)); acc(32'h3000, 0, 0, 1, 0, 0);
        ctx_type = 8'hF3; acc(32'h3000, 0, 0, 1, 0, 0);
        ctx_en = 0;
        @(negedge clk);

        // R8: global enables
        tag = "R8";
        wr(1, mk_ctl(1, 3, 3, 8'hFF, 1, 0, 0, 0, 0));
        mon_en = 0; acc(32'h3000, 0, 0, 1, 0, 0); mon_en = 1;
        dbg_exc_en = 0; acc(32'h3000, 0, 0, 1, 0, 0); dbg_exc_en = 1;
        acc(32'h3000, 0, 0, 1, 0, 0);
        @(negedge clk);

        // R9: byte-invariant address swizzle
        tag = "R9";
        be_invariant = 1;
        wr(0, 32'h4000);
        wr(1, mk_ctl(1, 3, 3, 8'h01, 1, 0, 0, 0, 0));
        acc(32'h4003, 0, 0, 1, 0, 0); acc(32'h4000, 0, 0, 1, 0, 0);
        acc(32'h4002, 1, 1, 1, 0, 0); acc(32'h4000, 1, 0, 1, 0, 0);
        acc(32'h4000, 2, 0, 1, 0, 0);
        be_invariant = 0;
        @(negedge clk);

        // R10: random accesses near the watched address, mixed with register writes
        tag = "R10";
        for (int i = 0; i < 3000; i++) begin
            bit [31:0] base;
            base = 32'h0001_0000 + ($urandom % 64);
            if ($urandom % 8 == 0) begin
                cfg_we = 1; cfg_sel = $urandom % 2;
                cfg_wdata = cfg_sel ? (mk_ctl(1, 2'($urandom), 2'($urandom), 8'($urandom), 1'($urandom),
                                              2'($urandom), 4'(3 + $urandom % 3), ($urandom % 4 == 0),
                                              ($urandom % 3 == 0) ? 5'($urandom % 9) : 5'd0))
                                    : base;
            end else cfg_we = 0;
            ctx_en = 2'($urandom); ctx_type = ($urandom % 2) ? 8'h7D : 8'($urandom);
            acc_ctx = 32'($urandom % 2); ctx_value = {32'($urandom % 2), 32'($urandom % 2)};
            mon_en = ($urandom % 16 != 0); dbg_exc_en = ($urandom % 16 != 0);
            be_invariant = ($urandom % 4 == 0);
            acc_valid = ($urandom % 4 != 0);
            acc_addr = 32'h0001_0000 + ($urandom % 96);
            acc_size = 2'($urandom); acc_write = 1'($urandom);
            acc_level = 2'($urandom); acc_unpriv = ($urandom % 4 == 0); acc_secure = 1'($urandom);
            @(negedge clk);
        end
        cfg_we = 0; acc_valid = 0;
        repeat (2) @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule